// File: doc/BRIEF.md
# Multichannel TDM Slot Receiver

The receiver listens on a serial data line that several devices share by time-division multiplexing. A frame sync marks the start of each frame. The frame is a run of channel slots that all have the same element size. The receiver shifts in every slot, but it forwards only the words from slots that the channel-enable configuration selects. Any number of receivers on the same line may select the same slot. Each forwarded word leaves with its channel number over a valid/ready handshake.

Channel selection has two modes. In block mode a 32-bit enable word covers two 16-channel sub-frames at a time. Its low half applies to one even-numbered sub-frame and its high half to one odd-numbered sub-frame, and two block selects choose which ones. A status output shows the sub-frame in progress, and an optional event pulses at the end of each sub-frame. Software uses these two signals to rewrite the half that is not in use while reception continues. In enhanced mode a 128-bit enable vector covers every channel directly.

The block runs on a fast system clock. It finds the falling edges of the bit clock and samples the frame sync and the data on those edges.

Top module: `tdm_slot_rx`

## Requirements
- R1: Data is sampled on falling edges of `bclk_i`, MSB first. `word_o` is right-justified and zero-filled to an element size set by `wlen_i`: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, and 4 or more gives 32.
- R2: A frame starts on the falling edge where `fsync_i` is first seen high. The MSB of channel 0 is sampled `delay_i` (0 to 2) falling edges after that edge.
- R3: A frame holds `nch_i`+1 channels. After the last one, data is ignored until the next frame sync.
- R4: In block mode, channel c (bits c[6:0]) is enabled when one of two conditions holds. Either c[4]=0, c[6:5]=`blk_a_i` and `chan_en_i`[c[3:0]]=1, or c[4]=1, c[6:5]=`blk_b_i` and `chan_en_i`[16+c[3:0]]=1. Bits 127:32 of `chan_en_i` are ignored.
- R5: In enhanced mode (`enh_mode_i`=1), channel c is enabled when `chan_en_i`[c]=1, and the block selects are ignored.
- R6: Only words from enabled channels appear at the output. Each is presented with its channel number on `chan_o`, and `valid_o`, `word_o` and `chan_o` hold until `ready_i` accepts the word.
- R7: If an enabled word completes while the previous word is still waiting and is not being accepted, the new word is dropped and `ovr_o` is set. `ovr_o` stays set until reset.
- R8: A frame sync that arrives before the current frame has received all its channels restarts the frame at channel 0 and sets `fs_err_o`. `fs_err_o` stays set until reset.
- R9: `cur_blk_o` shows the sub-frame (c[6:4]) of the channel being received. After a frame ends it holds the last sub-frame of that frame.
- R10: When `eos_en_i`=1, `eos_o` gives a one-cycle pulse as each channel with c[3:0]=15 completes, and as the last channel of the frame completes. When `eos_en_i`=0 it gives no pulse.
- R11: Enables are read when a word completes. A change to the inactive partition made during a sub-frame therefore takes effect for the sub-frames that follow.
- R12: After reset, `valid_o`, `eos_o`, `fs_err_o` and `ovr_o` are low and `cur_blk_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| fsync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data line |
| enh_mode_i | input | 1 | 1 = enhanced 128-channel enables |
| wlen_i | input | 3 | Element size code |
| nch_i | input | 7 | Channels per frame minus one |
| delay_i | input | 2 | Data delay in bit clocks |
| blk_a_i | input | 2 | Even sub-frame pair select |
| blk_b_i | input | 2 | Odd sub-frame pair select |
| chan_en_i | input | 128 | Channel enable vector |
| eos_en_i | input | 1 | End-of-sub-frame event enable |
| ready_i | input | 1 | Sink ready |
| valid_o | output | 1 | Word valid |
| word_o | output | 32 | Received word |
| chan_o | output | 7 | Channel of word |
| cur_blk_o | output | 3 | Active sub-frame |
| eos_o | output | 1 | End-of-sub-frame pulse |
| fs_err_o | output | 1 | Sticky early frame sync flag |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default parameters: 128 channels, a 32-bit maximum element size and enhanced mode present. The bit clock is set to one quarter of the system clock. Under these settings, enhanced mode is swept over every element-size code and every data delay. Block mode is swept over all sixteen block-select pairs on full 128-channel frames, so every sub-frame lands in each partition slot. Separate frames cover a mid-frame rewrite of the inactive partition, a truncated frame, a stalled sink and the event pulse with the enable on and off.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SKIP, ST_DATA} fr_state_e;

  function automatic logic [5:0] wlen_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int MAX_W = 32,
  parameter int NCH   = 128,
  localparam int CW   = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             sdata_i,
  input  logic [CW-1:0]    nch_i,
  input  logic [2:0]       wlen_i,
  input  logic [1:0]       delay_i,
  output logic             done_o,
  output logic [MAX_W-1:0] word_o,
  output logic [CW-1:0]    chan_o,
  output logic             sub_end_o,
  output logic [CW-1:0]    ch_cnt_o,
  output logic             fs_err_o
);
  fr_state_e        st;
  logic             bclk_q, fs_q;
  logic [1:0]       dcnt;
  logic [5:0]       bitcnt;
  logic [CW-1:0]    ch_cnt;
  logic [MAX_W-1:0] sh;

  logic             fall, fs_rise, data_edge, last_bit;
  logic [5:0]       wbits, bit_idx;
  logic [CW-1:0]    cur_ch;
  logic [MAX_W-1:0] sh_n;

  always_comb begin
    fall      = bclk_q & ~bclk_i;
    fs_rise   = fall & fsync_i & ~fs_q;
    data_edge = fall & (fs_rise ? (delay_i == 2'd0)
                                : ((st == ST_DATA) || (st == ST_SKIP && dcnt == 2'd0)));
    wbits     = wlen_bits(wlen_i);
    bit_idx   = fs_rise ? 6'd0 : bitcnt;
    cur_ch    = fs_rise ? '0 : ch_cnt;
    last_bit  = (bit_idx == wbits - 6'd1);
    sh_n      = (bit_idx == 6'd0) ? {{(MAX_W-1){1'b0}}, sdata_i} : {sh[MAX_W-2:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; bclk_q <= 1'b0; fs_q <= 1'b0; dcnt <= '0; bitcnt <= '0;
      ch_cnt <= '0; sh <= '0; done_o <= 1'b0; word_o <= '0; chan_o <= '0;
      sub_end_o <= 1'b0; fs_err_o <= 1'b0;
    end else begin
      bclk_q    <= bclk_i;
      done_o    <= 1'b0;
      sub_end_o <= 1'b0;
      if (fall) fs_q <= fsync_i;
      if (fs_rise) begin
        if (st != ST_IDLE) fs_err_o <= 1'b1;  // frame cut short
        ch_cnt <= '0;
        bitcnt <= '0;
        st     <= (delay_i == 2'd0) ? ST_DATA : ST_SKIP;
        dcnt   <= delay_i - 2'd1;
      end else if (fall && st == ST_SKIP && dcnt != 2'd0) begin
        dcnt <= dcnt - 2'd1;
      end
      if (data_edge) begin
        sh <= sh_n;
        if (last_bit) begin
          done_o    <= 1'b1;
          word_o    <= sh_n;
          chan_o    <= cur_ch;
          sub_end_o <= (cur_ch[3:0] == 4'hf) || (cur_ch == nch_i);
          bitcnt    <= '0;
          if (cur_ch == nch_i) begin
            st <= ST_IDLE;
          end else begin
            ch_cnt <= cur_ch + 1'b1;
            st     <= ST_DATA;
          end
        end else begin
          bitcnt <= bit_idx + 6'd1;
          st     <= ST_DATA;
        end
      end
    end
  end

  assign ch_cnt_o = ch_cnt;

  AST_FSERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_err_o |=> fs_err_o);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R1
endmodule

// File: rtl/tdm_rx_chsel.sv
module tdm_rx_chsel #(
  parameter int NCH     = 128,
  parameter bit HAS_ENH = 1'b1,
  localparam int CW     = $clog2(NCH),
  localparam int PW     = CW - 5
) (
  input  logic           enh_i,
  input  logic [PW-1:0]  blk_a_i,
  input  logic [PW-1:0]  blk_b_i,
  input  logic [NCH-1:0] en_i,
  input  logic [CW-1:0]  chan_i,
  output logic           hit_o
);
  logic std_hit;

  always_comb begin
    if (chan_i[4]) std_hit = (chan_i[CW-1:5] == blk_b_i) && en_i[{1'b1, chan_i[3:0]}];
    else           std_hit = (chan_i[CW-1:5] == blk_a_i) && en_i[{1'b0, chan_i[3:0]}];
  end

  generate
    if (HAS_ENH) begin : g_enh
      assign hit_o = enh_i ? en_i[chan_i] : std_hit;
    end else begin : g_std
      logic unused_enh;
      assign unused_enh = enh_i ^ (|en_i[NCH-1:32]);
      assign hit_o = std_hit;
    end
  endgenerate
endmodule

// File: rtl/tdm_rx_out.sv
module tdm_rx_out #(
  parameter int MAX_W = 32,
  parameter int CW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] word_i,
  input  logic [CW-1:0]    chan_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [MAX_W-1:0] word_o,
  output logic [CW-1:0]    chan_o,
  output logic             ovr_o
);
  logic busy;
  assign busy = valid_o & ~ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; word_o <= '0; chan_o <= '0; ovr_o <= 1'b0;
    end else if (load_i && busy) begin
      ovr_o <= 1'b1;  // drop newcomer
    end else if (load_i) begin
      valid_o <= 1'b1; word_o <= word_i; chan_o <= chan_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(word_o) && $stable(chan_o)));  // R6
  AST_LOAD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);  // R6
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);  // R7
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int MAX_W   = 32,
  parameter int NCH     = 128,
  parameter bit HAS_ENH = 1'b1,
  localparam int CW     = $clog2(NCH),
  localparam int PW     = CW - 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             sdata_i,
  input  logic             enh_mode_i,
  input  logic [2:0]       wlen_i,
  input  logic [CW-1:0]    nch_i,
  input  logic [1:0]       delay_i,
  input  logic [PW-1:0]    blk_a_i,
  input  logic [PW-1:0]    blk_b_i,
  input  logic [NCH-1:0]   chan_en_i,
  input  logic             eos_en_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [MAX_W-1:0] word_o,
  output logic [CW-1:0]    chan_o,
  output logic [CW-5:0]    cur_blk_o,
  output logic             eos_o,
  output logic             fs_err_o,
  output logic             ovr_o
);
  logic             done, sub_end, hit;
  logic [MAX_W-1:0] fr_word;
  logic [CW-1:0]    fr_chan, ch_cnt;

  tdm_rx_framer #(.MAX_W(MAX_W), .NCH(NCH)) u_framer (
    .clk_i, .rst_ni, .bclk_i, .fsync_i, .sdata_i,
    .nch_i, .wlen_i, .delay_i,
    .done_o(done), .word_o(fr_word), .chan_o(fr_chan),
    .sub_end_o(sub_end), .ch_cnt_o(ch_cnt), .fs_err_o
  );

  tdm_rx_chsel #(.NCH(NCH), .HAS_ENH(HAS_ENH)) u_chsel (
    .enh_i(enh_mode_i), .blk_a_i, .blk_b_i, .en_i(chan_en_i),
    .chan_i(fr_chan), .hit_o(hit)
  );

  tdm_rx_out #(.MAX_W(MAX_W), .CW(CW)) u_out (
    .clk_i, .rst_ni, .load_i(done & hit), .word_i(fr_word), .chan_i(fr_chan),
    .ready_i, .valid_o, .word_o, .chan_o, .ovr_o
  );

  assign cur_blk_o = ch_cnt[CW-1:4];
  assign eos_o     = done & sub_end & eos_en_i;

  AST_EOS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |=> !eos_o);  // R10
  AST_EOS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eos_en_i |-> !eos_o);  // R10
endmodule

// File: tb/tdm_slot_rx_tb_top.sv
module tdm_slot_rx_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bclk = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic         enh = 1'b1, eos_en = 1'b1, ready = 1'b1;
  logic [2:0]   wlen = 3'd0;
  logic [6:0]   nch = 7'd0;
  logic [1:0]   dly = 2'd0, blk_a = 2'd0, blk_b = 2'd0;
  logic [127:0] en = '0;
  logic         valid_o, eos_o, fs_err_o, ovr_o;
  logic [31:0]  word_o;
  logic [6:0]   chan_o;
  logic [2:0]   cur_blk_o;

  int checks = 0, fails = 0, eos_cnt = 0;
  logic [38:0] exp_q[$], got_q[$];

  always #5 clk = ~clk;

  tdm_slot_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync), .sdata_i(sdata),
    .enh_mode_i(enh), .wlen_i(wlen), .nch_i(nch), .delay_i(dly), .blk_a_i(blk_a),
    .blk_b_i(blk_b), .chan_en_i(en), .eos_en_i(eos_en), .ready_i(ready),
    .valid_o(valid_o), .word_o(word_o), .chan_o(chan_o), .cur_blk_o(cur_blk_o),
    .eos_o(eos_o), .fs_err_o(fs_err_o), .ovr_o(ovr_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o && ready) got_q.push_back({chan_o, word_o});
    if (rst_n && eos_o) eos_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic int wb_of(input logic [2:0] code);
    case (code)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16; 3'd3: return 20;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] val(input int c, input int seed, input int wb);
    logic [63:0] v, m;
    v = (64'(c) * 64'h9E3779B1 + 64'(seed) * 64'h7F4A7C15) ^ (64'(c) << 3);
    m = (64'd1 << wb) - 64'd1;
    return 32'(v & m);
  endfunction

  function automatic bit en_exp(input int c);
    int s;
    s = c / 16;
    if (enh) return en[c];
    if (s % 2 == 0) return (s / 2 == int'(blk_a)) && en[c % 16];
    return (s / 2 == int'(blk_b)) && en[16 + c % 16];
  endfunction

  task automatic bit_time(input logic fs, input logic d);
    @(negedge clk); bclk = 1'b1; fsync = fs; sdata = d;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    repeat (1) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input int seed, input int cut);
    int wb, total, idx, c;
    logic [31:0] w;
    wb = wb_of(wlen);
    total = n * wb;
    for (int k = 0; k < int'(dly) + total; k++) begin
      if (k < int'(dly)) bit_time(k == 0, 1'b1);
      else begin
        idx = k - int'(dly);
        c = idx / wb;
        if (cut >= 0 && c >= cut) break;
        w = val(c, seed, wb);
        bit_time(k == 0, w[wb - 1 - idx % wb]);
      end
    end
    for (int k = 0; k < 3; k++) bit_time(1'b0, 1'b1);
  endtask

  task automatic expect_frame(input int n, input int seed, input int upto);
    for (int c = 0; c < n && c < upto; c++)
      if (en_exp(c)) exp_q.push_back({7'(c), val(c, seed, wb_of(wlen))});
  endtask

  task automatic compare(input string tag);
    repeat (10) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " R3 R6 word count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {tag, " word/chan"}, got_q[i], exp_q[i]);
    exp_q.delete(); got_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    logic [15:0] new_low;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(valid_o == 1'b0 && eos_o == 1'b0, "R12 valid/eos after reset", {valid_o, eos_o}, 0);
    chk(fs_err_o == 1'b0 && ovr_o == 1'b0, "R12 flags after reset", {fs_err_o, ovr_o}, 0);
    chk(cur_blk_o == 3'd0, "R12 cur_blk after reset", cur_blk_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R5: enhanced sweep over element sizes and delays, block selects varied (ignored)
    seed = 1;
    enh = 1'b1; nch = 7'd19;
    for (int w = 0; w < 5; w++)
      for (int d = 0; d < 3; d++) begin
        wlen = 3'(w); dly = 2'(d);
        blk_a = 2'(w); blk_b = 2'(d + 1);
        en = {4{32'h5A3C_96E1 ^ (32'(seed) * 32'h01010101)}};
        expect_frame(20, seed, 999);
        send_frame(20, seed, -1);
        compare($sformatf("R1 R2 R5 wlen=%0d dly=%0d", w, d));
        seed++;
      end
    chk(fs_err_o == 1'b0, "R8 no error on complete frames", fs_err_o, 0);

    // R4: block mode, all block-select pairs, upper enable bits set (ignored)
    enh = 1'b0; wlen = 3'd0; dly = 2'd1; nch = 7'd127;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        blk_a = 2'(a); blk_b = 2'(b);
        en = {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'hC3A5_6E19 ^ 32'(a * 4 + b)};
        expect_frame(128, seed, 999);
        send_frame(128, seed, -1);
        compare($sformatf("R4 blk_a=%0d blk_b=%0d", a, b));
        seed++;
      end
    chk(cur_blk_o == 3'd7, "R9 cur_blk holds last sub-frame", cur_blk_o, 7);

    // R11: rewrite inactive partition while sub-frame 1 is received
    blk_a = 2'd0; blk_b = 2'd0; nch = 7'd47; dly = 2'd0;
    en = {96'd0, 32'hB7D1_5AC3};
    new_low = 16'h3CE5;
    expect_frame(48, seed, 16);
    for (int c = 16; c < 32; c++)
      if (en[c]) exp_q.push_back({7'(c), val(c, seed, 8)});
    for (int c = 32; c < 48; c++)
      if (new_low[c % 16]) exp_q.push_back({7'(c), val(c, seed, 8)});
    fork
      send_frame(48, seed, -1);
      begin
        wait (cur_blk_o == 3'd1);
        chk(1'b1, "R9 cur_blk reaches sub-frame 1", cur_blk_o, 1);
        repeat (8) @(negedge clk);
        blk_a = 2'd1; en[15:0] = new_low;
      end
    join
    compare("R11 mid-frame partition rewrite");
    seed++;

    // R10: end-of-sub-frame events with 40 channels
    enh = 1'b1; en = '0; nch = 7'd39; eos_cnt = 0; eos_en = 1'b1;
    send_frame(40, seed, -1);
    repeat (10) @(negedge clk);
    chk(eos_cnt == 3, "R10 eos pulses enabled", eos_cnt, 3);
    chk(cur_blk_o == 3'd2, "R9 cur_blk after 40-channel frame", cur_blk_o, 2);
    chk(got_q.size() == 0, "R6 no output with all disabled", got_q.size(), 0);
    eos_cnt = 0; eos_en = 1'b0;
    send_frame(40, seed, -1);
    repeat (10) @(negedge clk);
    chk(eos_cnt == 0, "R10 eos pulses disabled", eos_cnt, 0);
    got_q.delete();
    eos_en = 1'b1;

    // R8: truncated frame followed by a fresh frame
    en = '1; nch = 7'd7; wlen = 3'd1; dly = 2'd2;
    expect_frame(8, seed, 3);
    send_frame(8, seed, 3);
    seed++;
    expect_frame(8, seed, 999);
    send_frame(8, seed, -1);
    compare("R8 restart after early sync");
    chk(fs_err_o == 1'b1, "R8 sticky frame-sync error", fs_err_o, 1);

    // R7: stalled sink
    chk(ovr_o == 1'b0, "R7 no overrun before stall", ovr_o, 0);
    @(posedge clk); #2 ready = 1'b0;
    nch = 7'd2; wlen = 3'd0; dly = 2'd0; seed++;
    send_frame(3, seed, -1);
    repeat (5) @(negedge clk);
    chk(valid_o == 1'b1, "R6 valid held while stalled", valid_o, 1);
    chk(word_o == val(0, seed, 8) && chan_o == 7'd0, "R7 first word kept", {chan_o, word_o}, {7'd0, val(0, seed, 8)});
    chk(ovr_o == 1'b1, "R7 overrun flag set", ovr_o, 1);
    @(posedge clk); #2 ready = 1'b1;
    exp_q.push_back({7'd0, val(0, seed, 8)});
    compare("R7 only held word delivered");
    chk(ovr_o == 1'b1, "R7 overrun flag sticky", ovr_o, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule